// File: doc/BRIEF.md
# Trace Unit Control Register

This block is the single control word of an on-chip program trace unit. Software writes and reads it over a plain strobe bus. The stored fields drive the trace unit's control outputs: how many bytes of the context identifier are forwarded, cycle-accurate mode, branch broadcasting, return-stack use, a three-bit auxiliary field, the programming-mode flag and a power-down pin with its inverted power-up twin. The block also forwards the context identifier with the unselected upper bytes forced to zero.

When power-down is set, the block gates writes. Only the power-down bit and the auxiliary field accept new data, and every other field keeps its value. A debug-request handshake is also part of the block. If the debug-request enable is set when a trigger arrives, the block raises a request to the processor. The request stays high until the processor acknowledges it.

Top module: `trc_ctl_reg`

## Requirements
- R1: After reset the word reads 0x0000_0401: programming mode (bit 10) is 1, power-down (bit 0) is 1, and every other field is 0. `dbg_req` is low and `pwr_up` is low.
- R2: While `rd_en` is high, `rdata` returns the stored word in the same cycle. While `rd_en` is low, `rdata` is zero.
- R3: While the stored power-down bit is 0, a write with `wr_en` high loads all implemented fields from `wdata` at the next clock edge. The implemented fields are bits 29, 27:25, 15:14, 12, 10, 9, 8 and 0.
- R4: Bit 7, the reserved bits 13, 11 and 6:1, and every bit not listed in R3 always read as 0, whatever is written to them.
- R5: While the stored power-down bit is 1, a write changes only bit 0 and bits 27:25. All other fields keep their previous values.
- R6: The context-size field (bits 15:14) selects the forwarded bytes of `ctxid_in`: 00 forwards none (all zero), 01 forwards bits 7:0, 10 forwards bits 15:0 and 11 forwards bits 31:0. The higher bits of `ctxid_out` are zero. `ctxid_bytes` shows the field.
- R7: `cyc_acc_en` follows bit 12, `prog_mode` follows bit 10, `branch_bcast_en` follows bit 8, `ret_stack_en` follows bit 29 and `aux_ctl` follows bits 27:25.
- R8: `pwr_down` follows bit 0 and `pwr_up` is its inverse.
- R9: When bit 9 is 1 and `trigger` is high at a clock edge, `dbg_req` is high from that edge on and stays high until an acknowledge arrives.
- R10: When `dbg_ack` is sampled high, `dbg_req` is low after that edge. This holds even if `trigger` is high in the same cycle.
- R11: A trigger while bit 9 is 0 does not change `dbg_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data |
| trigger | input | 1 | Trigger event |
| dbg_ack | input | 1 | Debug acknowledge from the processor |
| dbg_req | output | 1 | Held debug request |
| ctxid_in | input | 32 | Current context identifier |
| ctxid_out | output | 32 | Context identifier with unselected bytes zeroed |
| ctxid_bytes | output | 2 | Context-size field |
| cyc_acc_en | output | 1 | Cycle-accurate enable |
| branch_bcast_en | output | 1 | Branch broadcast enable |
| ret_stack_en | output | 1 | Return-stack enable |
| prog_mode | output | 1 | Programming mode |
| aux_ctl | output | 3 | Auxiliary field, bits 27:25 |
| pwr_down | output | 1 | Power-down pin |
| pwr_up | output | 1 | Inverted power-down pin |

## Verification
A trigger and an acknowledge can reach the debug-request logic in the same cycle. The bench provokes every combination of enable, trigger, acknowledge and prior request state, one cycle at a time. It compares the request after each edge with the rule that an acknowledge clears the request and a trigger sets it only when enabled. A register write that changes the enable can also land beside a trigger. That case is covered by separating the write from the trigger and judging against the stored enable value.

// File: rtl/trc_ctl_pkg.sv
package trc_ctl_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned B_PDN    = 0;
  localparam int unsigned B_BCAST  = 8;
  localparam int unsigned B_DBGEN  = 9;
  localparam int unsigned B_PROG   = 10;
  localparam int unsigned B_CYC    = 12;
  localparam int unsigned B_CTX_LO = 14;
  localparam int unsigned B_AUX_LO = 25;
  localparam int unsigned B_RET    = 29;

  localparam logic [WORD_W-1:0] RW_MASK =
      (32'h1 << B_RET) | (32'h7 << B_AUX_LO) | (32'h3 << B_CTX_LO) |
      (32'h1 << B_CYC) | (32'h1 << B_PROG) | (32'h1 << B_DBGEN) |
      (32'h1 << B_BCAST) | (32'h1 << B_PDN);
  localparam logic [WORD_W-1:0] PD_MASK  = (32'h7 << B_AUX_LO) | (32'h1 << B_PDN);
  localparam logic [WORD_W-1:0] RST_WORD = (32'h1 << B_PROG) | (32'h1 << B_PDN);
endpackage

// File: rtl/trc_ctl_rst_sync.sv
module trc_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/trc_ctl_regfile.sv
module trc_ctl_regfile
  import trc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cfg_q
);
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] cfg_d;

  always_comb begin
    wmask = cfg_q[B_PDN] ? PD_MASK : RW_MASK;
    cfg_d = (cfg_q & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RST_WORD;
    else if (wr_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/trc_ctl_dbgreq.sv
module trc_ctl_dbgreq (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trigger,
  input  logic ack,
  output logic req_q
);
  logic req_d;

  always_comb begin
    req_d = req_q;
    if (ack)                  req_d = 1'b0;
    else if (trigger && enable) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/trc_ctl_ctxid.sv
module trc_ctl_ctxid #(
  parameter int unsigned CTX_W = 32
) (
  input  logic [1:0]       sel,
  input  logic [CTX_W-1:0] id_in,
  output logic [CTX_W-1:0] id_out
);
  localparam int unsigned NBYTES = CTX_W / 8;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic keep;
    always_comb begin
      case (sel)
        2'b01:   keep = (i < 1);
        2'b10:   keep = (i < 2);
        2'b11:   keep = 1'b1;
        default: keep = 1'b0;
      endcase
    end
    assign id_out[i*8 +: 8] = keep ? id_in[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/trc_ctl_reg.sv
module trc_ctl_reg
  import trc_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  input  logic        trigger,
  input  logic        dbg_ack,
  output logic        dbg_req,
  input  logic [31:0] ctxid_in,
  output logic [31:0] ctxid_out,
  output logic [1:0]  ctxid_bytes,
  output logic        cyc_acc_en,
  output logic        branch_bcast_en,
  output logic        ret_stack_en,
  output logic        prog_mode,
  output logic [2:0]  aux_ctl,
  output logic        pwr_down,
  output logic        pwr_up
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] cfg_q;

  trc_ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  trc_ctl_regfile u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wdata(wdata), .cfg_q(cfg_q)
  );

  trc_ctl_dbgreq u_dbg (
    .clk(clk), .rst_n(rst_sync_n), .enable(cfg_q[B_DBGEN]),
    .trigger(trigger), .ack(dbg_ack), .req_q(dbg_req)
  );

  trc_ctl_ctxid #(.CTX_W(32)) u_ctx (
    .sel(ctxid_bytes), .id_in(ctxid_in), .id_out(ctxid_out)
  );

  assign rdata           = rd_en ? cfg_q : '0;
  assign ctxid_bytes     = cfg_q[B_CTX_LO +: 2];
  assign cyc_acc_en      = cfg_q[B_CYC];
  assign branch_bcast_en = cfg_q[B_BCAST];
  assign ret_stack_en    = cfg_q[B_RET];
  assign prog_mode       = cfg_q[B_PROG];
  assign aux_ctl         = cfg_q[B_AUX_LO +: 3];
  assign pwr_down        = cfg_q[B_PDN];
  assign pwr_up          = ~cfg_q[B_PDN];
endmodule

// File: rtl/trc_ctl_reg_chk.sv
module trc_ctl_reg_chk
  import trc_ctl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] rdata,
  input logic [31:0] cfg,
  input logic        trigger,
  input logic        dbg_ack,
  input logic        dbg_req,
  input logic [1:0]  ctxid_bytes,
  input logic [31:0] ctxid_out
);
  // R10
  ack_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ack |=> !dbg_req);

  // R9
  req_held_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_req) |-> $past(dbg_ack));

  // R11
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_req) |-> $past(trigger && cfg[B_DBGEN]));

  // R5
  pd_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg[B_PDN]) |=> ((cfg & ~PD_MASK) == $past(cfg & ~PD_MASK)));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((rdata & ~RW_MASK) == 32'h0));

  // R6
  ctx_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctxid_bytes == 2'b00) |-> (ctxid_out == 32'h0));
endmodule

bind trc_ctl_reg trc_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .cfg(cfg_q), .trigger(trigger), .dbg_ack(dbg_ack), .dbg_req(dbg_req),
  .ctxid_bytes(ctxid_bytes), .ctxid_out(ctxid_out)
);

// File: tb/trc_ctl_reg_test.sv
module trc_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en, trigger, dbg_ack;
  logic [31:0] wdata, ctxid_in;
  logic [31:0] rdata, ctxid_out;
  logic [1:0]  ctxid_bytes;
  logic        dbg_req, cyc_acc_en, branch_bcast_en, ret_stack_en, prog_mode;
  logic        pwr_down, pwr_up;
  logic [2:0]  aux_ctl;

  int errors = 0;
  int checks = 0;
  logic [31:0] model;

  always #5 clk = ~clk;

  trc_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .trigger(trigger), .dbg_ack(dbg_ack), .dbg_req(dbg_req),
    .ctxid_in(ctxid_in), .ctxid_out(ctxid_out), .ctxid_bytes(ctxid_bytes),
    .cyc_acc_en(cyc_acc_en), .branch_bcast_en(branch_bcast_en),
    .ret_stack_en(ret_stack_en), .prog_mode(prog_mode), .aux_ctl(aux_ctl),
    .pwr_down(pwr_down), .pwr_up(pwr_up)
  );

  localparam logic [31:0] IMPL = 32'h2E00_D701;
  localparam logic [31:0] PDW  = 32'h0E00_0001;

  function automatic logic [31:0] next_word(logic [31:0] old, logic [31:0] w);
    logic [31:0] m;
    m = old[0] ? PDW : IMPL;
    return (old & ~m) | (w & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wdata = v;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    model = next_word(model, v);
  endtask

  task automatic read_chk(string req);
    rd_en = 1'b1;
    #1;
    chk(req, rdata, model);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic outs_chk();
    chk("R7", {29'd0, cyc_acc_en, branch_bcast_en, prog_mode},
        {29'd0, model[12], model[8], model[10]});
    chk("R7", {28'd0, ret_stack_en, aux_ctl}, {28'd0, model[29], model[27:25]});
    chk("R8", {30'd0, pwr_down, pwr_up}, {30'd0, model[0], ~model[0]});
  endtask

  task automatic pulse(logic t, logic a);
    @(negedge clk);
    trigger = t; dbg_ack = a;
    @(negedge clk);
    trigger = 1'b0; dbg_ack = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; trigger = 1'b0; dbg_ack = 1'b0;
    wdata = '0; ctxid_in = '0; model = 32'h0000_0401;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R1 reset state
    read_chk("R1");
    chk("R1", {30'd0, dbg_req, pwr_up}, 32'd0);
    outs_chk();
    // R2 idle read data
    chk("R2", rdata, 32'd0);

    // R3 R4 R5 walking ones through every bit position
    wr(32'h0);
    for (int i = 0; i < 32; i++) begin
      wr(32'h1 << i);
      read_chk(model[0] ? "R5" : "R3");
      rd_en = 1'b1; #1;
      chk("R4", rdata & ~IMPL, 32'd0);
      rd_en = 1'b0; #1;
      outs_chk();
    end

    // R3 all ones, then R5 gating while powered down
    wr(32'h0);
    wr(32'hFFFF_FFFF);
    read_chk("R3");
    chk("R3", model, 32'h2E00_D701);
    wr(32'h0);
    chk("R5", model, 32'h2000_D700);
    read_chk("R5");
    outs_chk();
    wr(32'hF1FF_FFFE);
    read_chk("R5");
    wr(32'h0E00_0000);
    read_chk("R5");

    // R6 exhaustive over size field with several identifier patterns
    wr(32'h0);
    wr(32'h0);
    for (int s = 0; s < 4; s++) begin
      wr(32'(s) << 14);
      chk("R6", {30'd0, ctxid_bytes}, 32'(s));
      for (int p = 0; p < 4; p++) begin
        logic [31:0] pat;
        logic [31:0] m;
        pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h1234_5678 :
              (p == 2) ? 32'h8000_0080 : 32'hA5C3_0F69;
        m = (s == 0) ? 32'h0 : (s == 1) ? 32'hFF : (s == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        ctxid_in = pat;
        #1;
        chk("R6", ctxid_out, pat & m);
      end
    end

    // R9 trigger sets and holds request
    wr(32'h200);
    pulse(1'b1, 1'b0);
    chk("R9", {31'd0, dbg_req}, 32'd1);
    repeat (4) @(negedge clk);
    #1;
    chk("R9", {31'd0, dbg_req}, 32'd1);
    pulse(1'b0, 1'b1);
    chk("R10", {31'd0, dbg_req}, 32'd0);

    // R9 R10 R11 every enable/trigger/ack/prior combination
    for (int c = 0; c < 16; c++) begin
      logic en, t, a, prior, expv;
      en = c[0]; t = c[1]; a = c[2]; prior = c[3];
      wr(32'h200);
      if (prior) pulse(1'b1, 1'b0);
      else       pulse(1'b0, 1'b1);
      wr({22'd0, en, 9'd0});
      pulse(t, a);
      expv = a ? 1'b0 : ((t && en) ? 1'b1 : prior);
      chk(a ? "R10" : (en ? "R9" : "R11"), {31'd0, dbg_req}, {31'd0, expv});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule